// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This block executes the four unaligned partial-word instructions of a 32-bit load/store pipeline: load-left, load-right, store-left and store-right. For each request it takes an effective byte address, the current contents of the destination or source register, and a two-bit operation code. It then talks to a word-wide memory port and returns the merged result. Only the aligned word that contains the addressed byte is ever touched, and the low address bits choose how many byte lanes move and in which direction.

Loads read the aligned word once. They combine some of its bytes with the bytes of the old register value that are kept, and hand the result back with a one-cycle completion strobe. Stores read the aligned word, replace the selected lanes with register bytes, and write the merged word back to the same address. No per-byte write strobe is used. A load whose destination is the hard-wired zero register still performs its memory read, but its register-write qualifier stays low.

Top module: `partial_word_merge_unit`

## Requirements
- R1: Every memory access presents the request address with its two low bits cleared.
- R2: Op code 2'b00 (load-left) with offset k returns memory byte j in register byte j+3-k for j = 0..k. The register bytes below lane 3-k keep their old values. Example: offset 0 keeps the low three register bytes and places memory byte 0 in the top byte.
- R3: Op code 2'b01 (load-right) with offset k returns memory byte j+k in register byte j for j = 0..3-k. The register bytes above lane 3-k keep their old values.
- R4: Op code 2'b10 (store-left) with offset k writes register byte j+3-k to memory byte j for j = 0..k. The other memory bytes keep their old values.
- R5: Op code 2'b11 (store-right) with offset k writes register byte j to memory byte j+k for j = 0..3-k. The other memory bytes keep their old values.
- R6: A store performs exactly one read, then exactly one write to the same aligned address, carrying the merged word.
- R7: A load performs exactly one read and no write.
- R8: When the destination-is-zero flag is set, a load still performs its read but `done_wr_en` stays low. Otherwise `done_wr_en` is high with `done` for every load and low for every store.
- R9: `done` is a single-cycle pulse per request. In that cycle `done_data` holds the merged value: the register result for a load, the written word for a store.
- R10: While `mem_valid` is high and `mem_ready` is low, the unit holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R11: `req_ready` is high only while the unit is idle. A request offered while the unit is busy, including the `done` cycle, is not taken until the unit returns to idle.
- R12: After reset, `req_ready` is high and both `mem_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request taken on valid and ready |
| req_op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| req_addr | input | 32 | Effective byte address |
| req_reg | input | 32 | Current register value |
| req_dest_zero | input | 1 | Destination is the zero register |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access (read data valid this cycle) |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged store word |
| mem_rdata | input | 32 | Read data, sampled when valid and ready are both high |
| done | output | 1 | Completion pulse |
| done_wr_en | output | 1 | Register write qualifier for loads |
| done_data | output | 32 | Merged value |

## Verification
Two events can meet in one cycle. The first is completion of one request, with `done` high. The second is a new request waiting at the input. The bench raises the next request in the very cycle it sees `done`, checks that `req_ready` is low there, and then checks that the second operation runs fully and correctly. The other overlap is a memory port that answers in the same cycle the access is raised. This is compared against a port that inserts wait states, with a monitor confirming the request is held unchanged while it waits.

// File: rtl/pwm_pkg.sv
// Shared types for the partial-word merge unit.
// Assumes a two-bit operation code driven by the instruction decoder.
package pwm_pkg;

    typedef enum logic [1:0] {
        OP_LD_LEFT  = 2'b00,
        OP_LD_RIGHT = 2'b01,
        OP_ST_LEFT  = 2'b10,
        OP_ST_RIGHT = 2'b11
    } pw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10,
        ST_DONE  = 2'b11
    } pw_state_e;

endpackage

// File: rtl/pwm_shift_merge.sv
// Lane shifter and merger.
// Moves the source word (memory for loads, register for stores) by a whole
// number of lanes and fills the uncovered lanes from the other operand.
// Assumes DATA_W is a power-of-two multiple of LANE_W. Purely combinational.
module pwm_shift_merge
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  pw_op_e              op,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [DATA_W-1:0]   reg_val,
    input  logic [DATA_W-1:0]   mem_val,
    output logic [DATA_W-1:0]   merged
);

    localparam logic [OFS_W-1:0] LAST_OFS = {OFS_W{1'b1}};

    logic                dir_left;
    logic [OFS_W-1:0]    amt;
    logic [DATA_W-1:0]   src;
    logic [DATA_W-1:0]   other;
    logic [DATA_W-1:0]   moved;
    logic [LANES-1:0]    take_new;

    // Pick direction, lane count and operands from the operation.
    always_comb begin
        dir_left = (op == OP_LD_LEFT) || (op == OP_ST_RIGHT);
        if ((op == OP_LD_LEFT) || (op == OP_ST_LEFT)) begin
            amt = LAST_OFS - ofs;
        end else begin
            amt = ofs;
        end
        if ((op == OP_ST_LEFT) || (op == OP_ST_RIGHT)) begin
            src   = reg_val;
            other = mem_val;
        end else begin
            src   = mem_val;
            other = reg_val;
        end
        moved = dir_left ? (src << (int'(amt) * LANE_W))
                         : (src >> (int'(amt) * LANE_W));
    end

    // One selector per lane: shifted lane or kept lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign take_new[g] = dir_left ? (int'(amt) <= g) : (int'(amt) < (LANES - g));
        assign merged[g*LANE_W +: LANE_W] = take_new[g] ? moved[g*LANE_W +: LANE_W]
                                                        : other[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/pwm_ctrl.sv
// Sequencer for the partial-word merge unit.
// Accepts one request when idle. Issues an aligned read, then for stores an
// aligned write of the merged word, then pulses done for one cycle.
// Assumes memory read data is valid in the cycle mem_ready is high.
module pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_reg,
    input  logic                req_dest_zero,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   merged,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                done,
    output logic                done_wr_en,
    output logic [DATA_W-1:0]   done_data,
    output pw_op_e              op_q,
    output logic [OFS_W-1:0]    ofs_q,
    output logic [DATA_W-1:0]   reg_q
);

    pw_state_e           state_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   result_q;
    logic                dz_q;
    logic                is_store;

    assign is_store = (op_q == OP_ST_LEFT) || (op_q == OP_ST_RIGHT);
    assign ofs_q    = addr_q[OFS_W-1:0];

    // State sequencing and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_LD_LEFT;
            addr_q   <= '0;
            reg_q    <= '0;
            dz_q     <= 1'b0;
            result_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= pw_op_e'(req_op);
                        addr_q  <= req_addr;
                        reg_q   <= req_reg;
                        dz_q    <= req_dest_zero;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        result_q <= merged;
                        state_q  <= is_store ? ST_WRITE : ST_DONE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Port-side decode of the current state.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_valid  = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we     = (state_q == ST_WRITE);
        mem_addr   = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        mem_wdata  = result_q;
        done       = (state_q == ST_DONE);
        done_wr_en = done && !is_store && !dz_q;
        done_data  = result_q;
    end

endmodule

// File: rtl/partial_word_merge_unit.sv
// Top of the partial-word merge unit.
// Joins the sequencer with the lane merger. The merger sees live memory read
// data, so the merged word is captured in the read handshake cycle.
// Assumes one outstanding request and a single word-wide memory port.
module partial_word_merge_unit
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_reg,
    input  logic                req_dest_zero,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic                done_wr_en,
    output logic [DATA_W-1:0]   done_data
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int OFS_W = $clog2(LANES);

    pw_op_e              op_q;
    logic [OFS_W-1:0]    ofs_q;
    logic [DATA_W-1:0]   reg_q;
    logic [DATA_W-1:0]   merged;

    pwm_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_reg       (req_reg),
        .req_dest_zero (req_dest_zero),
        .mem_ready     (mem_ready),
        .merged        (merged),
        .mem_valid     (mem_valid),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .done          (done),
        .done_wr_en    (done_wr_en),
        .done_data     (done_data),
        .op_q          (op_q),
        .ofs_q         (ofs_q),
        .reg_q         (reg_q)
    );

    pwm_shift_merge #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .OFS_W  (OFS_W)
    ) u_merge (
        .op      (op_q),
        .ofs     (ofs_q),
        .reg_val (reg_q),
        .mem_val (mem_rdata),
        .merged  (merged)
    );

endmodule

// File: rtl/pwm_checker.sv
// Protocol checker for the partial-word merge unit, bound to the top.
// Tracks the kind of the accepted request and the last read address.
module pwm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [1:0]          req_op,
    input logic                req_dest_zero,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                done,
    input logic                done_wr_en
);

    logic                ld_q;
    logic                dz_q;
    logic [ADDR_W-1:0]   rd_addr_q;

    // Remember request kind and the address of the last completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q      <= 1'b0;
            dz_q      <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            if (req_valid && req_ready) begin
                ld_q <= !req_op[1];
                dz_q <= req_dest_zero;
            end
            if (mem_valid && mem_ready && !mem_we) begin
                rd_addr_q <= mem_addr;
            end
        end
    end

    assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFS_W-1:0] == '0));

    assert_same_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (mem_addr == rd_addr_q));

    assert_load_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> !ld_q);

    assert_zero_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr_en |-> (done && ld_q && !dz_q));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || done) |-> !req_ready);

endmodule

bind partial_word_merge_unit pwm_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_dest_zero (req_dest_zero),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .done          (done),
    .done_wr_en    (done_wr_en)
);

// File: tb/sim_partial_word_merge_unit.sv
`timescale 1ns/1ps
// Directed bench for the partial-word merge unit: one task per scenario.
module sim_partial_word_merge_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_reg = '0;
    logic        req_dest_zero = 1'b0;
    logic        mem_valid;
    logic        mem_ready;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        done;
    logic        done_wr_en;
    logic [31:0] done_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem_q [0:15];
    int wait_cfg = 0;
    int wait_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic        hold_prev = 1'b0;
    logic [31:0] hold_addr = '0;
    logic        hold_we = 1'b0;

    always #4 clk = ~clk;

    partial_word_merge_unit u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_reg       (req_reg),
        .req_dest_zero (req_dest_zero),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .done          (done),
        .done_wr_en    (done_wr_en),
        .done_data     (done_data)
    );

    // Memory model with programmable wait states.
    assign mem_ready = mem_valid && (wait_cnt >= wait_cfg);
    assign mem_rdata = mem_q[mem_addr[5:2]];

    always @(posedge clk) begin
        if (mem_valid && !mem_ready) wait_cnt <= wait_cnt + 1;
        else wait_cnt <= 0;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem_q[mem_addr[5:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
            end else begin
                rd_cnt <= rd_cnt + 1;
                last_rd_addr <= mem_addr;
            end
        end
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Stability monitor for a waiting memory request (R10).
    always @(negedge clk) begin
        if (rst_n && hold_prev && mem_valid) begin
            check32("R10 addr held", mem_addr, hold_addr);
            check32("R10 we held", {31'b0, mem_we}, {31'b0, hold_we});
        end
        hold_prev <= mem_valid && !mem_ready;
        hold_addr <= mem_addr;
        hold_we   <= mem_we;
    end

    // Byte-wise reference merge, written from R2..R5.
    function automatic logic [31:0] ref_merge(input logic [1:0] op, input int k,
                                              input logic [31:0] r, input logic [31:0] m);
        logic [31:0] res;
        res = 32'h0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            case (op)
                2'b00: b = (i >= 3 - k) ? m[8*(i-(3-k)) +: 8] : r[8*i +: 8];
                2'b01: b = (i <= 3 - k) ? m[8*(i+k) +: 8]     : r[8*i +: 8];
                2'b10: b = (i <= k)     ? r[8*(i+3-k) +: 8]   : m[8*i +: 8];
                default: b = (i >= k)   ? r[8*(i-k) +: 8]     : m[8*i +: 8];
            endcase
            res[8*i +: 8] = b;
        end
        return res;
    endfunction

    // Offer a request at a negedge; returns at the negedge after acceptance.
    task automatic start_req(input logic [1:0] op, input logic [31:0] addr,
                             input logic [31:0] r, input logic dz);
        logic take;
        req_valid = 1'b1;
        req_op = op;
        req_addr = addr;
        req_reg = r;
        req_dest_zero = dz;
        forever begin
            take = req_ready;
            @(posedge clk);
            if (take) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Poll at negedges until done is seen.
    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 60) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Check everything a completed request should show.
    task automatic check_result(input string tag, input logic [1:0] op, input logic [31:0] addr,
                                input logic [31:0] r, input logic dz, input logic [31:0] m0,
                                input int rd0, input int wr0);
        logic [31:0] exp;
        logic is_st;
        is_st = op[1];
        exp = ref_merge(op, int'(addr[1:0]), r, m0);
        check32({tag, " R9 done seen"}, {31'b0, done}, 32'd1);
        check32({tag, " R2-5 merged value R9"}, done_data, exp);
        check32({tag, " R8 wr_en"}, {31'b0, done_wr_en}, {31'b0, !is_st && !dz});
        check32({tag, " R6 R7 reads"}, rd_cnt - rd0, 1);
        check32({tag, " R6 R7 writes"}, wr_cnt - wr0, is_st ? 1 : 0);
        check32({tag, " R1 read addr"}, last_rd_addr, {addr[31:2], 2'b00});
        if (is_st) begin
            check32({tag, " R6 write addr"}, last_wr_addr, {addr[31:2], 2'b00});
            check32({tag, " R4 R5 memory"}, mem_q[addr[5:2]], exp);
        end else begin
            check32({tag, " R7 memory kept"}, mem_q[addr[5:2]], m0);
        end
    endtask

    task automatic run_op(input string tag, input logic [1:0] op, input logic [31:0] addr,
                          input logic [31:0] r, input logic dz, input logic [31:0] m0);
        int rd0;
        int wr0;
        mem_q[addr[5:2]] = m0;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        start_req(op, addr, r, dz);
        wait_done();
        check_result(tag, op, addr, r, dz, m0, rd0, wr0);
        @(negedge clk);
        check32({tag, " R9 pulse ends"}, {31'b0, done}, 32'd0);
        check32({tag, " R11 ready again"}, {31'b0, req_ready}, 32'd1);
    endtask

    task automatic test_reset();
        check32("R12 ready", {31'b0, req_ready}, 32'd1);
        check32("R12 mem_valid", {31'b0, mem_valid}, 32'd0);
        check32("R12 done", {31'b0, done}, 32'd0);
    endtask

    task automatic test_load_left();
        for (int k = 0; k < 4; k++)
            run_op("R2 load-left", 2'b00, 32'h0000_0010 + k, 32'hAABB_CCDD, 1'b0, 32'h1234_5678);
    endtask

    task automatic test_load_right();
        for (int k = 0; k < 4; k++)
            run_op("R3 load-right", 2'b01, 32'h0000_0024 + k, 32'hAABB_CCDD, 1'b0, 32'h1234_5678);
    endtask

    task automatic test_store_left();
        for (int k = 0; k < 4; k++)
            run_op("R4 store-left", 2'b10, 32'h0000_0038 + k, 32'hAABB_CCDD, 1'b0, 32'h1234_5678);
    endtask

    task automatic test_store_right();
        for (int k = 0; k < 4; k++)
            run_op("R5 store-right", 2'b11, 32'h0000_000C + k, 32'hAABB_CCDD, 1'b0, 32'h1234_5678);
    endtask

    task automatic test_zero_dest();
        run_op("R8 zero dest LL", 2'b00, 32'h0000_0031, 32'h0F0F_0F0F, 1'b1, 32'hCAFE_BABE);
        run_op("R8 zero dest LR", 2'b01, 32'h0000_0032, 32'h0F0F_0F0F, 1'b1, 32'hCAFE_BABE);
        run_op("R8 zero flag on store", 2'b10, 32'h0000_0033, 32'h0F0F_0F0F, 1'b1, 32'hCAFE_BABE);
    endtask

    task automatic test_wait_states();
        wait_cfg = 3;
        run_op("R10 wait LL", 2'b00, 32'h0000_0015, 32'h1111_2222, 1'b0, 32'h8899_AABB);
        run_op("R10 wait SR", 2'b11, 32'h0000_0016, 32'h1111_2222, 1'b0, 32'h8899_AABB);
        run_op("R10 wait SL", 2'b10, 32'h0000_0017, 32'h1111_2222, 1'b0, 32'h8899_AABB);
        wait_cfg = 0;
    endtask

    task automatic test_overlap();
        int rd0;
        int wr0;
        mem_q[4'h5] = 32'hDEAD_BEEF;
        mem_q[4'h6] = 32'h0102_0304;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        start_req(2'b11, 32'h0000_0015, 32'h5566_7788, 1'b0);
        wait_done();
        check_result("R11 first", 2'b11, 32'h0000_0015, 32'h5566_7788, 1'b0, 32'hDEAD_BEEF, rd0, wr0);
        check32("R11 not ready during done", {31'b0, req_ready}, 32'd0);
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        start_req(2'b01, 32'h0000_001A, 32'h99AA_BBCC, 1'b0);
        wait_done();
        check_result("R11 second", 2'b01, 32'h0000_001A, 32'h99AA_BBCC, 1'b0, 32'h0102_0304, rd0, wr0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_q[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_load_left();
        test_load_right();
        test_store_left();
        test_store_right();
        test_zero_dest();
        test_wait_states();
        test_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule